// File: doc/BRIEF.md
# Banked Cartridge Mapper with Scanline Interrupt

This block sits between a console CPU and the cartridge memories. It turns CPU writes into the bank numbers that the pattern-memory and program-memory address decoders need. The pattern space is eight 1KB pages and the program window is four 8KB slots. The bank registers are reached indirectly. The CPU first writes a command byte that names a target register and two layout bits. It then writes the bank number to the data port. One layout bit swaps the two outer program slots. The other moves the pattern banks between the low and high halves of the pattern space.

The block also produces a nametable mirroring select and a scanline interrupt. An external detector pulses `line_tick` once per visible scanline. An 8-bit down counter reloads from a latch when it reaches zero. It raises the CPU interrupt on the tick where it reaches zero from a nonzero value, provided that interrupts are enabled and rendering is active. The interrupt stays high until software writes the disable register.

Top module: `scanline_bank_mapper`

## Requirements
- R1: After reset, all of the following hold. Pattern page i maps bank i. Program slot 0 holds 0x1E and slot 1 holds 0x1F, both masked to the ROM size. Slot 2 holds the second-to-last bank and slot 3 the last bank. `mirror_o` is 0 (vertical), or 2 when the board is strapped for four screens. `irq_o` is low, and the counter, latch and command are all 0.
- R2: A write selects its register by `cpu_addr & 0x6001`. 0x0000 is command, 0x0001 is data, 0x2000 is mirroring, 0x2001 is ignored, 0x4000 is reload value, 0x4001 is counter clear, 0x6000 is IRQ disable and 0x6001 is IRQ enable. A write to 0x2001 changes no output.
- R3: Command bits 2:0 name the target register. With target 0 or 1, a data write maps two pages. The first page is (target×2) XOR (command bit 7 ? 4 : 0) and gets the data with bit 0 cleared. The next page up gets the data with bit 0 set.
- R4: With target 2 to 5, a data write maps page (target+2) XOR (command bit 7 ? 4 : 0) to the data value.
- R5: Target 6 stores the swappable program bank and target 7 sets slot 1. When command bit 6 is 0, slot 0 gets the stored bank and slot 2 gets the second-to-last bank. When bit 6 is 1, the two are exchanged. A command write reapplies this layout at once. Slot 3 always holds the last bank.
- R6: Every bank number is masked to the low CHR_PAGE_W or PRG_BANK_W bits of the data.
- R7: A mirroring write sets `mirror_o` to data bit 0 (1 = horizontal, 0 = vertical). On a board strapped for four screens, the write is ignored and `mirror_o` stays 2. The value 3 never appears.
- R8: On each `line_tick`, the counter loads the latch value if it is zero, and otherwise decrements by one.
- R9: `irq_o` rises one clock after a tick when all of these hold: interrupts are enabled, `render_on` is high, and the counter goes from nonzero to zero on that tick. It then stays high until disabled.
- R10: A write to the disable register clears the enable and drops `irq_o` on the next clock. A write to 0x4001 zeroes the counter, so the next tick reloads it.
- R11: Pattern and program outputs change only on data or command writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | CPU write strobe into the mapper window |
| cpu_addr | input | 15 | Write offset within the program window |
| cpu_data | input | 8 | Write data |
| line_tick | input | 1 | One-cycle pulse per visible scanline |
| render_on | input | 1 | Rendering active during the tick |
| chr_page_o | output | 8×CHR_PAGE_W | Bank for each 1KB pattern page; page i at bits [i×CHR_PAGE_W +: CHR_PAGE_W] |
| prg_slot_o | output | 4×PRG_BANK_W | Bank for each 8KB program slot; slot s at bits [s×PRG_BANK_W +: PRG_BANK_W] |
| mirror_o | output | 2 | 0 vertical, 1 horizontal, 2 four-screen |
| irq_o | output | 1 | CPU interrupt request |

## Verification
The bench sweeps all eight targets under all four combinations of the swap and inversion bits, with data values that include 0x00, 0xFF and alternating patterns. These values expose an error in page placement, in the pair's low bit, in masking or in slot exchange. The interrupt is checked with reload values 1 through 6, one tick before and one tick after it should fire, which pins the count down exactly. Separate runs with rendering off, with the enable off, with a zero latch and with a clear partway through the count show which of the four firing conditions each fault breaks. Aliased addresses and the ignored register confirm that only the masked offset bits select a register.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  typedef enum logic [2:0] {
    SEL_CMD      = 3'd0,
    SEL_DATA     = 3'd1,
    SEL_MIRROR   = 3'd2,
    SEL_WRAM     = 3'd3,
    SEL_RELOAD   = 3'd4,
    SEL_CLEAR    = 3'd5,
    SEL_IRQ_OFF  = 3'd6,
    SEL_IRQ_ON   = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    MIR_VERT = 2'd0,
    MIR_HORZ = 2'd1,
    MIR_FOUR = 2'd2
  } mirror_e;

  // Register select: only address bits 14, 13 and 0 take part.
  function automatic reg_sel_e decode_reg(input logic [14:0] addr);
    logic [14:0] m;
    m = addr & 15'h6001;
    case (m)
      15'h0000: return SEL_CMD;
      15'h0001: return SEL_DATA;
      15'h2000: return SEL_MIRROR;
      15'h2001: return SEL_WRAM;
      15'h4000: return SEL_RELOAD;
      15'h4001: return SEL_CLEAR;
      15'h6000: return SEL_IRQ_OFF;
      default:  return SEL_IRQ_ON;
    endcase
  endfunction

  // First pattern page touched by a target (0..5) under the inversion bit.
  function automatic logic [2:0] chr_first_page(input logic [2:0] tgt, input logic inv);
    logic [2:0] base;
    base = (tgt < 3'd2) ? {tgt[1:0], 1'b0} : tgt + 3'd2;
    return base ^ {inv, 2'b00};
  endfunction

  // Scanline counter step.
  function automatic logic [7:0] count_step(input logic [7:0] cnt, input logic [7:0] latch);
    return (cnt == 8'd0) ? latch : cnt - 8'd1;
  endfunction

endpackage

// File: rtl/mapper_bank_regs.sv
module mapper_bank_regs
  import mapper_pkg::*;
#(
  parameter int CHR_PAGE_W  = 7,
  parameter int PRG_BANK_W  = 4,
  parameter bit FOUR_SCREEN = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_cmd,
  input  logic                    wr_data,
  input  logic                    wr_mirror,
  input  logic [7:0]              wdata,
  output logic                    swap_q,
  output logic [PRG_BANK_W-1:0]   prg_a_q,
  output logic [PRG_BANK_W-1:0]   prg_b_q,
  output logic [8*CHR_PAGE_W-1:0] chr_q,
  output logic [1:0]              mirror_q
);

  localparam logic [PRG_BANK_W-1:0] PRG_RST_A = PRG_BANK_W'(8'h1E);
  localparam logic [PRG_BANK_W-1:0] PRG_RST_B = PRG_BANK_W'(8'h1F);
  localparam logic [1:0]            MIR_RST   = FOUR_SCREEN ? MIR_FOUR : MIR_VERT;

  logic [2:0] tgt_q;
  logic       inv_q;
  logic [2:0] first_pg;
  logic       is_pair;
  logic       is_chr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= 3'd0;
      inv_q  <= 1'b0;
      swap_q <= 1'b0;
    end else if (wr_cmd) begin
      tgt_q  <= wdata[2:0];
      swap_q <= wdata[6];
      inv_q  <= wdata[7];
    end
  end

  assign first_pg = chr_first_page(tgt_q, inv_q);
  assign is_pair  = (tgt_q < 3'd2);
  assign is_chr   = (tgt_q <= 3'd5);

  for (genvar g = 0; g < 8; g++) begin : g_page
    localparam logic [2:0] PG = 3'(g);
    logic                  hit;
    logic [CHR_PAGE_W-1:0] val;
    logic [CHR_PAGE_W-1:0] page_q;

    assign hit = wr_data && is_chr &&
                 (is_pair ? (PG[2:1] == first_pg[2:1]) : (PG == first_pg));
    assign val = is_pair ? {wdata[CHR_PAGE_W-1:1], PG[0]} : wdata[CHR_PAGE_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n)   page_q <= CHR_PAGE_W'(g);
      else if (hit) page_q <= val;
    end

    assign chr_q[g*CHR_PAGE_W +: CHR_PAGE_W] = page_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prg_a_q <= PRG_RST_A;
      prg_b_q <= PRG_RST_B;
    end else if (wr_data) begin
      if (tgt_q == 3'd6) prg_a_q <= wdata[PRG_BANK_W-1:0];
      if (tgt_q == 3'd7) prg_b_q <= wdata[PRG_BANK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       mirror_q <= MIR_RST;
    else if (wr_mirror && !FOUR_SCREEN) mirror_q <= wdata[0] ? MIR_HORZ : MIR_VERT;
  end

endmodule

// File: rtl/prg_slot_map.sv
module prg_slot_map #(
  parameter int PRG_BANK_W = 4
) (
  input  logic                  swap,
  input  logic [PRG_BANK_W-1:0] bank_a,
  input  logic [PRG_BANK_W-1:0] bank_b,
  output logic [4*PRG_BANK_W-1:0] slots
);

  localparam logic [PRG_BANK_W-1:0] LAST = '1;
  localparam logic [PRG_BANK_W-1:0] PENULT = LAST - 1'b1;

  for (genvar s = 0; s < 4; s++) begin : g_slot
    logic [PRG_BANK_W-1:0] b;
    if (s == 0) begin : g_s0
      assign b = swap ? PENULT : bank_a;
    end else if (s == 1) begin : g_s1
      assign b = bank_b;
    end else if (s == 2) begin : g_s2
      assign b = swap ? bank_a : PENULT;
    end else begin : g_s3
      assign b = LAST;
    end
    assign slots[s*PRG_BANK_W +: PRG_BANK_W] = b;
  end

endmodule

// File: rtl/scanline_irq_ctr.sv
module scanline_irq_ctr
  import mapper_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_tick,
  input  logic       render_on,
  input  logic       wr_reload,
  input  logic       wr_clear,
  input  logic       wr_irq_off,
  input  logic       wr_irq_on,
  input  logic [7:0] wdata,
  output logic       irq_q,
  output logic       fire
);

  logic [7:0] cnt_q;
  logic [7:0] latch_q;
  logic [7:0] cnt_nxt;
  logic       en_q;

  assign cnt_nxt = count_step(cnt_q, latch_q);
  assign fire = line_tick && !wr_clear && en_q && render_on &&
                (cnt_nxt == 8'd0) && (cnt_q != 8'd0);

  always_ff @(posedge clk) begin
    if (!rst_n)         latch_q <= 8'd0;
    else if (wr_reload) latch_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= 8'd0;
    else if (wr_clear)  cnt_q <= 8'd0;
    else if (line_tick) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          en_q <= 1'b0;
    else if (wr_irq_off) en_q <= 1'b0;
    else if (wr_irq_on)  en_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          irq_q <= 1'b0;
    else if (wr_irq_off) irq_q <= 1'b0;
    else if (fire)       irq_q <= 1'b1;
  end

endmodule

// File: rtl/scanline_bank_mapper.sv
module scanline_bank_mapper
  import mapper_pkg::*;
#(
  parameter int CHR_PAGE_W  = 7,
  parameter int PRG_BANK_W  = 4,
  parameter bit FOUR_SCREEN = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_we,
  input  logic [14:0]             cpu_addr,
  input  logic [7:0]              cpu_data,
  input  logic                    line_tick,
  input  logic                    render_on,
  output logic [8*CHR_PAGE_W-1:0] chr_page_o,
  output logic [4*PRG_BANK_W-1:0] prg_slot_o,
  output logic [1:0]              mirror_o,
  output logic                    irq_o
);

  reg_sel_e sel;
  logic wr_cmd, wr_data, wr_mirror, wr_reload, wr_clear, wr_irq_off, wr_irq_on;
  logic swap_q;
  logic [PRG_BANK_W-1:0] prg_a_q, prg_b_q;
  logic irq_fire;

  assign sel        = decode_reg(cpu_addr);
  assign wr_cmd     = cpu_we && (sel == SEL_CMD);
  assign wr_data    = cpu_we && (sel == SEL_DATA);
  assign wr_mirror  = cpu_we && (sel == SEL_MIRROR);
  assign wr_reload  = cpu_we && (sel == SEL_RELOAD);
  assign wr_clear   = cpu_we && (sel == SEL_CLEAR);
  assign wr_irq_off = cpu_we && (sel == SEL_IRQ_OFF);
  assign wr_irq_on  = cpu_we && (sel == SEL_IRQ_ON);

  mapper_bank_regs #(
    .CHR_PAGE_W (CHR_PAGE_W),
    .PRG_BANK_W (PRG_BANK_W),
    .FOUR_SCREEN(FOUR_SCREEN)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_cmd),
    .wr_data  (wr_data),
    .wr_mirror(wr_mirror),
    .wdata    (cpu_data),
    .swap_q   (swap_q),
    .prg_a_q  (prg_a_q),
    .prg_b_q  (prg_b_q),
    .chr_q    (chr_page_o),
    .mirror_q (mirror_o)
  );

  prg_slot_map #(.PRG_BANK_W(PRG_BANK_W)) u_slots (
    .swap  (swap_q),
    .bank_a(prg_a_q),
    .bank_b(prg_b_q),
    .slots (prg_slot_o)
  );

  scanline_irq_ctr u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .render_on (render_on),
    .wr_reload (wr_reload),
    .wr_clear  (wr_clear),
    .wr_irq_off(wr_irq_off),
    .wr_irq_on (wr_irq_on),
    .wdata     (cpu_data),
    .irq_q     (irq_o),
    .fire      (irq_fire)
  );

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
  parameter int CHR_PAGE_W  = 7,
  parameter int PRG_BANK_W  = 4,
  parameter bit FOUR_SCREEN = 1'b0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    line_tick,
  input logic                    render_on,
  input logic                    wr_cmd,
  input logic                    wr_data,
  input logic                    wr_mirror,
  input logic                    wr_irq_off,
  input logic                    irq_fire,
  input logic [8*CHR_PAGE_W-1:0] chr_page_o,
  input logic [4*PRG_BANK_W-1:0] prg_slot_o,
  input logic [1:0]              mirror_o,
  input logic                    irq_o
);

  localparam logic [PRG_BANK_W-1:0] LAST   = '1;
  localparam logic [PRG_BANK_W-1:0] PENULT = LAST - 1'b1;

  AST_SLOT3_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    prg_slot_o[3*PRG_BANK_W +: PRG_BANK_W] == LAST); // R5

  AST_OUTER_SLOT_PENULT: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_slot_o[0 +: PRG_BANK_W] == PENULT) ||
    (prg_slot_o[2*PRG_BANK_W +: PRG_BANK_W] == PENULT)); // R5

  AST_IRQ_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_off |=> !irq_o); // R10

  AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(line_tick && render_on && irq_fire)); // R9

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_irq_off) |=> irq_o); // R9

  AST_CHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data |=> $stable(chr_page_o)); // R11

  AST_PRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_data || wr_cmd) |=> $stable(prg_slot_o)); // R11

  AST_MIRROR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    FOUR_SCREEN ? (mirror_o == 2'd2) : (mirror_o != 2'd3 && mirror_o != 2'd2)); // R7

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mirror |=> $stable(mirror_o)); // R7

endmodule

bind scanline_bank_mapper mapper_checker #(
  .CHR_PAGE_W (CHR_PAGE_W),
  .PRG_BANK_W (PRG_BANK_W),
  .FOUR_SCREEN(FOUR_SCREEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_tick (line_tick),
  .render_on (render_on),
  .wr_cmd    (wr_cmd),
  .wr_data   (wr_data),
  .wr_mirror (wr_mirror),
  .wr_irq_off(wr_irq_off),
  .irq_fire  (irq_fire),
  .chr_page_o(chr_page_o),
  .prg_slot_o(prg_slot_o),
  .mirror_o  (mirror_o),
  .irq_o     (irq_o)
);

// File: tb/tb_scanline_bank_mapper.sv
module tb_scanline_bank_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 7;
  localparam int PW = 4;
  localparam int CMASK = (1 << CW) - 1;
  localparam int PMASK = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0;
  logic [14:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic line_tick = 1'b0;
  logic render_on = 1'b1;
  logic [8*CW-1:0] chr_page, chr_page_fs;
  logic [4*PW-1:0] prg_slot, prg_slot_fs;
  logic [1:0] mirror, mirror_fs;
  logic irq, irq_fs;

  int vectors = 0;
  int miscompares = 0;
  int exp_page[8];
  int exp_a, exp_b;
  bit exp_swap;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_bank_mapper #(.CHR_PAGE_W(CW), .PRG_BANK_W(PW), .FOUR_SCREEN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .line_tick(line_tick), .render_on(render_on), .chr_page_o(chr_page),
    .prg_slot_o(prg_slot), .mirror_o(mirror), .irq_o(irq));

  scanline_bank_mapper #(.CHR_PAGE_W(CW), .PRG_BANK_W(PW), .FOUR_SCREEN(1'b1)) dut_fs (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .line_tick(line_tick), .render_on(render_on), .chr_page_o(chr_page_fs),
    .prg_slot_o(prg_slot_fs), .mirror_o(mirror_fs), .irq_o(irq_fs));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a[14:0]; cpu_data = d[7:0];
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
  endtask

  function automatic int slot_exp(input int s);
    case (s)
      0: return exp_swap ? PMASK - 1 : exp_a;
      1: return exp_b;
      2: return exp_swap ? exp_a : PMASK - 1;
      default: return PMASK;
    endcase
  endfunction

  task automatic check_slots(input string req);
    for (int s = 0; s < 4; s++) chk(req, int'(prg_slot[s*PW +: PW]), slot_exp(s));
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) chk(req, int'(chr_page[i*CW +: CW]), exp_page[i]);
    check_slots(req);
  endtask

  // Bench model of one data write to target tgt.
  task automatic model_data(input int tgt, input bit inv, input int d);
    int base;
    if (tgt < 2) begin
      base = (tgt * 2) ^ (inv ? 4 : 0);
      exp_page[base]     = (d & CMASK) & ~1;
      exp_page[base + 1] = (d & CMASK) | 1;
    end else if (tgt < 6) begin
      exp_page[(tgt + 2) ^ (inv ? 4 : 0)] = d & CMASK;
    end else if (tgt == 6) begin
      exp_a = d & PMASK;
    end else begin
      exp_b = d & PMASK;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int dv[5];
    for (int i = 0; i < 8; i++) exp_page[i] = i;
    exp_a = 8'h1E & PMASK;
    exp_b = 8'h1F & PMASK;
    exp_swap = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_all("R1");
    chk("R1", int'(mirror), 0);
    chk("R1", int'(irq), 0);
    chk("R1", int'(mirror_fs), 2);

    // R3 R4 R5 R6 sweep of targets, layout bits and data patterns
    for (int inv = 0; inv < 2; inv++) begin
      for (int sw = 0; sw < 2; sw++) begin
        for (int tgt = 0; tgt < 8; tgt++) begin
          dv[0] = 8'h00; dv[1] = 8'h55; dv[2] = 8'hAA; dv[3] = 8'hFF;
          dv[4] = (8'h13 + tgt * 8'h11 + inv * 3 + sw * 7) & 8'hFF;
          for (int k = 0; k < 5; k++) begin
            wr(16'h0000, (inv << 7) | (sw << 6) | tgt);
            exp_swap = sw[0];
            check_slots("R5");
            wr(16'h0001, dv[k]);
            model_data(tgt, inv[0], dv[k]);
            if (tgt < 2)      check_all("R3");
            else if (tgt < 6) check_all("R4");
            else              check_all("R5");
          end
        end
      end
    end

    // R6 explicit masking
    wr(16'h0000, 2);
    wr(16'h0001, 8'hFF);
    chk("R6", int'(chr_page[4*CW +: CW]), CMASK);
    wr(16'h0000, 7);
    wr(16'h0001, 8'hF3);
    chk("R6", int'(prg_slot[1*PW +: PW]), 3);
    exp_page[4] = CMASK; exp_b = 3; exp_swap = 1'b0;

    // R2 aliased offsets: cmd via 0x1FFE, data via 0x1235
    wr(16'h1FFE, 8'h83);
    wr(16'h1235, 8'h21);
    model_data(3, 1'b1, 8'h21);
    check_all("R2");
    // R2 ignored register 0x2001 (aliased at 0x3FFF)
    wr(16'h3FFF, 8'hFF);
    wr(16'h2001, 8'h01);
    check_all("R2");
    chk("R2", int'(mirror), 0);
    chk("R2", int'(irq), 0);

    // R7 mirroring
    wr(16'h2000, 8'h01);
    chk("R7", int'(mirror), 1);
    chk("R7", int'(mirror_fs), 2);
    wr(16'h2000, 8'h02);
    chk("R7", int'(mirror), 0);
    wr(16'h3FFE, 8'hFF);
    chk("R7", int'(mirror), 1);
    chk("R7", int'(mirror_fs), 2);

    // R8 R9 counting windows
    render_on = 1'b1;
    for (int n = 1; n <= 6; n++) begin
      wr(16'h4000, n);
      wr(16'h4001, 0);
      wr(16'h6001, 0);
      for (int t = 1; t <= n; t++) begin
        tick();
        chk("R8", int'(irq), 0);
      end
      tick();
      chk("R9", int'(irq), 1);
      tick();
      chk("R9", int'(irq), 1);
      wr(16'h6000, 0);
      chk("R10", int'(irq), 0);
    end

    // R10 clear mid-count; count is n=6 reloaded at last tick, clear first
    wr(16'h4000, 3);
    wr(16'h4001, 0);
    wr(16'h6001, 0);
    tick(); tick();
    wr(16'h4001, 0);
    tick(); tick(); tick();
    chk("R10", int'(irq), 0);
    tick();
    chk("R10", int'(irq), 1);
    wr(16'h6000, 0);
    chk("R10", int'(irq), 0);

    // R9 rendering off: no interrupt
    wr(16'h4000, 2);
    wr(16'h4001, 0);
    wr(16'h6001, 0);
    render_on = 1'b0;
    tick(); tick(); tick();
    chk("R9", int'(irq), 0);
    render_on = 1'b1;

    // R9 enable off: no interrupt
    wr(16'h6000, 0);
    wr(16'h4001, 0);
    tick(); tick(); tick();
    chk("R9", int'(irq), 0);

    // R8 zero latch: counter never leaves zero
    wr(16'h4000, 0);
    wr(16'h4001, 0);
    wr(16'h6001, 0);
    for (int t = 0; t < 4; t++) begin
      tick();
      chk("R8", int'(irq), 0);
    end
    wr(16'h6000, 0);

    // R11 banks untouched by interrupt and mirroring traffic
    check_all("R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule